// File: doc/BRIEF.md
# Bit-Serial Dual-Rail Adder

This block adds two W-bit operands plus a carry-in using a single full-adder stage that is reused once per bit, least significant bit first. Two shift registers present one bit of each operand per step, and a third shift register gathers the sum bits. The operand bits and the carry travel as dual-rail pairs. Each pair is either empty, a valid 0 or a valid 1, so the stage can tell from the data itself when its inputs are complete. The sum bit leaves the stage single-rail.

Every bit step has two parts. In the data phase the operand pair and carry pair carry codewords, with their request signals raised. In the spacer phase every pair returns to empty and the stage completion drops. The carry produced by one bit is held as a dual-rail pair and becomes the carry input of the next bit.

The host loads both operands, picks an initial carry and strobes start. After the last bit, the sum, the final carry and a one-cycle finish pulse appear together. A clocked handshake stands in for the self-timed circuit.

Top module: `serial_dr_adder`

## Requirements
- R1: When a run finishes, `sum_out` equals (A + B + `cin`) mod 2^W and `carry_out` equals bit W of that sum, where A and B are the operands loaded before start. `sum_out` changes only in the cycle `finish` is high.
- R2: Each internal dual-rail pair uses 00 = empty, 01 = logic 0 and 10 = logic 1. The code 11 never appears.
- R3: Between two bit steps every operand and carry pair is 00, and `bit_done` is low for at least one cycle after each high cycle.
- R4: `bit_done` is high in exactly the data phase of each bit step, so it is high for exactly W cycles during one run.
- R5: If `start` is sampled while idle, `busy` rises at that edge and `finish` is high in the cycle after the 2W-th rising edge counted from that edge inclusive. `busy` is low from that same edge on.
- R6: `finish` is high for exactly one cycle per run.
- R7: While `busy` is high, `load` and `start` have no effect. The run completes with the result of the operands and carry-in it started with.
- R8: After reset `busy`, `finish`, `bit_done`, `carry_out` and `sum_out` are all zero.
- R9: `load` while idle captures `a_in` and `b_in`. A `load` together with `start` in the same cycle runs on the newly loaded operands. A run consumes its operands, so each run needs a fresh load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| load | input | 1 | capture operands when idle |
| a_in | input | W | operand A |
| b_in | input | W | operand B |
| cin | input | 1 | initial carry for bit 0 |
| start | input | 1 | begin a run when idle |
| sum_out | output | W | sum of the last run |
| carry_out | output | 1 | final carry of the last run |
| busy | output | 1 | a run is in progress |
| finish | output | 1 | one-cycle pulse when the result is ready |
| bit_done | output | 1 | stage completion for the current bit |

## Verification
The bench covers the longest carry ripple: all-ones plus one, all-ones plus an injected carry-in, and all-ones plus all-ones with carry. A design that dropped the fed-back carry, or took it from the wrong rail, would give a wrong sum or final carry there. Zero plus zero exposes a carry register that starts at empty or at logic 1. A design that skipped the spacer would show `bit_done` high in two cycles in a row, or a count other than W per run. Operands reloaded and start strobed in the middle of a run check that a busy block ignores both; a design that honoured them would finish with a different sum or at the wrong time.

// File: rtl/serial_dr_adder.sv
module serial_dr_adder #(
  parameter int W = 32,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         cin,
  input  logic         start,
  output logic [W-1:0] sum_out,
  output logic         carry_out,
  output logic         busy,
  output logic         finish,
  output logic         bit_done
);

  logic [W-1:0]  a_sh, b_sh, s_sh;
  logic [1:0]    c_q;
  logic [CW-1:0] bit_cnt;
  logic          phase;

  logic [1:0] a_dr, b_dr, c_dr, co_dr;
  logic       req_ab, req_c, s_bit;

  assign req_ab = busy & phase;
  assign req_c  = busy & phase;

  assign a_dr = req_ab ? {a_sh[0], ~a_sh[0]} : 2'b00;
  assign b_dr = req_ab ? {b_sh[0], ~b_sh[0]} : 2'b00;
  assign c_dr = req_c  ? c_q : 2'b00;

  assign co_dr[1] = (a_dr[1] & b_dr[1]) | (a_dr[1] & c_dr[1]) | (b_dr[1] & c_dr[1]);
  assign co_dr[0] = (a_dr[0] & b_dr[0]) | (a_dr[0] & c_dr[0]) | (b_dr[0] & c_dr[0]);

  assign bit_done = (|a_dr) & (|b_dr) & (|c_dr) & (|co_dr);
  assign s_bit    = bit_done & (a_dr[1] ^ b_dr[1] ^ c_dr[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sh      <= '0;
      b_sh      <= '0;
      s_sh      <= '0;
      c_q       <= 2'b00;
      bit_cnt   <= '0;
      phase     <= 1'b0;
      busy      <= 1'b0;
      finish    <= 1'b0;
      sum_out   <= '0;
      carry_out <= 1'b0;
    end else begin
      finish <= 1'b0;
      if (!busy) begin
        if (load) begin
          a_sh <= a_in;
          b_sh <= b_in;
        end
        if (start) begin
          busy    <= 1'b1;
          phase   <= 1'b1;
          bit_cnt <= '0;
          c_q     <= cin ? 2'b10 : 2'b01;
        end
      end else if (phase) begin
        if (bit_done) begin
          s_sh  <= {s_bit, s_sh[W-1:1]};
          a_sh  <= {1'b0, a_sh[W-1:1]};
          b_sh  <= {1'b0, b_sh[W-1:1]};
          c_q   <= co_dr;
          phase <= 1'b0;
          if (bit_cnt == CW'(W-1)) begin
            busy      <= 1'b0;
            finish    <= 1'b1;
            sum_out   <= {s_bit, s_sh[W-1:1]};
            carry_out <= co_dr[1];
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end else begin
        phase <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dr_adder_chk.sv
module dr_adder_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   a_dr,
  input logic [1:0]   b_dr,
  input logic [1:0]   c_dr,
  input logic [1:0]   co_dr,
  input logic         req_ab,
  input logic         req_c,
  input logic         bit_done,
  input logic         busy,
  input logic         finish,
  input logic [W-1:0] sum_out
);

  assert_no_illegal_a_R2: assert property (@(posedge clk) disable iff (!rst_n) a_dr != 2'b11);
  assert_no_illegal_b_R2: assert property (@(posedge clk) disable iff (!rst_n) b_dr != 2'b11);
  assert_no_illegal_c_R2: assert property (@(posedge clk) disable iff (!rst_n) c_dr != 2'b11);
  assert_no_illegal_co_R2: assert property (@(posedge clk) disable iff (!rst_n) co_dr != 2'b11);

  assert_spacer_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> (a_dr == 2'b00 && b_dr == 2'b00 && c_dr == 2'b00 && !bit_done));

  assert_req_gives_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ab && req_c) |-> bit_done);

  assert_done_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> busy);

  assert_finish_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish);

  assert_finish_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> !busy);

  assert_sum_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |-> $stable(sum_out));

endmodule

bind serial_dr_adder dr_adder_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_dr(a_dr), .b_dr(b_dr), .c_dr(c_dr),
  .co_dr(co_dr), .req_ab(req_ab), .req_c(req_c), .bit_done(bit_done),
  .busy(busy), .finish(finish), .sum_out(sum_out)
);

// File: tb/test_serial_dr_adder.sv
module test_serial_dr_adder;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         cin = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] sum_out;
  logic         carry_out, busy, finish, bit_done;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  serial_dr_adder #(.W(W)) i_serial_dr_adder (
    .clk(clk), .rst_n(rst_n), .load(load), .a_in(a_in), .b_in(b_in),
    .cin(cin), .start(start), .sum_out(sum_out), .carry_out(carry_out),
    .busy(busy), .finish(finish), .bit_done(bit_done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // runs one add; ign=1 reloads and restarts mid-run (R7)
  task automatic t_add(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci, input bit ign);
    logic [W:0] ref_v;
    int n, dn;
    bit prev, twice;
    ref_v = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    @(negedge clk);
    a_in = a; b_in = b; cin = ci; load = 1'b1; start = 1'b1;   // R9: load with start
    n = 0; dn = 0; prev = 1'b0; twice = 1'b0;
    while (1) begin
      @(posedge clk); n++;
      @(negedge clk);
      load = 1'b0; start = 1'b0;
      if (n == 1) chk(busy == 1'b1, "R5 busy rises", 64'(busy), 64'd1);
      if (ign && n == 7) begin
        a_in = ~a; b_in = a ^ b; cin = ~ci; load = 1'b1; start = 1'b1;
      end
      if (bit_done) begin dn++; if (prev) twice = 1'b1; end
      prev = bit_done;
      if (finish || n > 4 * W) break;
    end
    chk(n == 2 * W, "R5 latency", 64'(n), 64'(2 * W));
    chk(!busy, "R5 busy low at finish", 64'(busy), 64'd0);
    chk(sum_out == ref_v[W-1:0], ign ? "R7 sum" : "R1 sum", 64'(sum_out), 64'(ref_v[W-1:0]));
    chk(carry_out == ref_v[W], ign ? "R7 carry" : "R1 carry", 64'(carry_out), 64'(ref_v[W]));
    chk(dn == W, "R4 bit_done count", 64'(dn), 64'(W));
    chk(!twice, "R3 spacer between bits", 64'(twice), 64'd0);
    load = 1'b0; start = 1'b0;
    @(negedge clk);
    chk(!finish, "R6 finish one cycle", 64'(finish), 64'd0);
    chk(sum_out == ref_v[W-1:0], "R1 sum held", 64'(sum_out), 64'(ref_v[W-1:0]));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !finish && !bit_done, "R8 flags", {61'd0, busy, finish, bit_done}, 64'd0);
    chk(sum_out == '0 && !carry_out, "R8 result", 64'(sum_out), 64'd0);
  endtask

  // R9: operands consumed; start without reload adds zeros plus cin
  task automatic t_noreload();
    int n;
    @(negedge clk);
    cin = 1'b1; start = 1'b1;
    n = 0;
    while (1) begin
      @(negedge clk); start = 1'b0; n++;
      if (finish || n > 4 * W) break;
    end
    chk(sum_out == W'(1) && !carry_out, "R9 consumed operands", 64'(sum_out), 64'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_add('0, '0, 1'b0, 1'b0);
    t_add('1, W'(1), 1'b0, 1'b0);
    t_add('1, '0, 1'b1, 1'b0);
    t_add('1, '1, 1'b1, 1'b0);
    t_add(W'(32'h1234_5678), W'(32'h0FED_CBA9), 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) t_add(W'($urandom), W'($urandom), 1'($urandom), 1'b0);
    t_noreload();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule